// File: doc/BRIEF.md
# Interrupt Redirection Entry Controller

This block keeps a single 64-bit redirection entry and turns one external interrupt pin into a message request for a downstream delivery path. Software accesses the entry as a low and a high 32-bit word. The pin is synchronized and its polarity is corrected, so the rest of the logic always sees an active-high input. The entry's trigger setting and delivery mode then decide how the input is qualified: as a rising edge, or as a level that is gated by a remote-acknowledge flag.

When the input qualifies, the block raises a request. The request carries the vector, the delivery mode, the destination mode and the resolved destination. It stays up until the downstream side accepts it through a valid/ready handshake. The low word shows, read-only, whether a request is outstanding and whether a level interrupt is waiting for its end-of-interrupt.

Top module: `irq_route_entry`

## Requirements
- R1: After reset the low word reads 0x0001_0000 (only the mask bit 16 is set), the high word reads 0, and no request is raised.
- R2: A low-word write updates the vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], trigger [15] and mask [16]. Bits 12 and 14 and all other bits ignore the write data. A high-word write stores only bits [31:24] (the destination); every other high-word bit reads 0.
- R3: The pin passes through two synchronizer flops. A qualifying edge on the pin shows up as a raised request after the third rising clock edge that follows the pin change.
- R4: In edge operation, a rising edge of the conditioned input raises a request only if the entry is unmasked and no request is already pending. An edge that arrives while the entry is masked, or while a request is pending, is dropped. Low-word bit 12 reads 1 exactly while a request is pending.
- R5: Level operation applies only to fixed (000) and lowest-priority (001) modes with trigger bit 15 set. In level operation, an active input with bit 14 clear raises a request. Acceptance sets bit 14, and no further request is raised while bit 14 is set.
- R6: An end-of-interrupt whose vector equals the entry vector clears bit 14. If the input is still active, a new request follows. An end-of-interrupt carrying a different vector has no effect.
- R7: System-management (010), NMI (100), INIT (101) and external-controller (111) modes act as edge triggered even when bit 15 is 1. Their acceptance never sets bit 14, and a held input gives exactly one request.
- R8: Delivery-mode codes 011 and 110 never raise a request.
- R9: A raised request stays valid, with stable fields, until ready is high. The cycle after valid and ready are both high, valid and bit 12 are low.
- R10: In physical mode (bit 11 = 0) the request destination is {4'b0, entry[59:56]}. In logical mode (bit 11 = 1) it is entry[63:56].
- R11: With polarity bit 13 set, the pin is active low: a high-to-low pin transition is the qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_lo_i | input | 1 | Write strobe for the low entry word |
| wr_hi_i | input | 1 | Write strobe for the high entry word |
| wdata_i | input | 32 | Write data |
| rdata_lo_o | output | 32 | Low entry word readback |
| rdata_hi_o | output | 32 | High entry word readback |
| irq_pin_i | input | 1 | Asynchronous interrupt pin |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | 8 | Vector carried by the end-of-interrupt |
| req_valid_o | output | 1 | Message request valid |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_vector_o | output | 8 | Request vector |
| req_mode_o | output | 3 | Request delivery mode |
| req_logical_o | output | 1 | Request destination mode (1 = logical) |
| req_dest_o | output | 8 | Request destination |

## Verification
The bench targets the cases where a trigger rule is easy to get wrong. A design that honoured the trigger bit for NMI mode would set the remote flag and stall after the first request. A design that latched edges seen while masked or while a request was pending would emit a spurious second request. A design that compared the end-of-interrupt vector loosely would release a level interrupt early. The bench also drives reserved mode codes, which a careless decoder would let through as requests. It checks the physical-mode destination truncation and the exact three-edge latency of the synchronizer. Finally, a long random stretch of pin, ready, end-of-interrupt and register traffic is compared on every cycle against a behavioural model.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int VEC_W   = 8;
  localparam int DEST_W  = 8;
  localparam int PHYS_W  = 4;
  localparam int WORD_W  = 32;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSV3   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_RSV6   = 3'b110,
    DM_EXTINT = 3'b111
  } dmode_e;

  typedef struct packed {
    logic              mask;
    logic              level;
    logic              polarity;
    logic              logical;
    dmode_e            mode;
    logic [VEC_W-1:0]  vec;
    logic [DEST_W-1:0] dest;
  } cfg_t;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              logical;
    dmode_e            mode;
    logic [VEC_W-1:0]  vec;
  } msg_t;
endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic polarity_i,
  output logic cond_o,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  // active-high after polarity correction
  assign cond_o = sync_q[SYNC_STAGES-1] ^ polarity_i;
  assign edge_o = cond_o & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cond_o;
endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
  import irq_entry_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pending_i,
  input  logic              irr_i,
  output cfg_t              cfg_o,
  output logic [WORD_W-1:0] rdata_lo_o,
  output logic [WORD_W-1:0] rdata_hi_o
);
  localparam int LO_USED = 17;
  localparam int HI_PAD  = WORD_W - DEST_W;

  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      cfg_q.mask <= 1'b1;
    end else begin
      if (wr_lo_i) begin
        cfg_q.vec      <= wdata_i[7:0];
        cfg_q.mode     <= dmode_e'(wdata_i[10:8]);
        cfg_q.logical  <= wdata_i[11];
        cfg_q.polarity <= wdata_i[13];
        cfg_q.level    <= wdata_i[15];
        cfg_q.mask     <= wdata_i[16];
      end
      if (wr_hi_i) cfg_q.dest <= wdata_i[WORD_W-1 -: DEST_W];
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[WORD_W-1:LO_USED], wdata_i[14], wdata_i[12]};

  assign cfg_o      = cfg_q;
  assign rdata_lo_o = {{(WORD_W-LO_USED){1'b0}}, cfg_q.mask, cfg_q.level, irr_i,
                       cfg_q.polarity, pending_i, cfg_q.logical, cfg_q.mode, cfg_q.vec};
  assign rdata_hi_o = {cfg_q.dest, {HI_PAD{1'b0}}};
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic             cond_i,
  input  logic             edge_i,
  input  logic             eoi_valid_i,
  input  logic [VEC_W-1:0] eoi_vector_i,
  input  logic             ready_i,
  output logic             valid_o,
  output msg_t             msg_o,
  output logic             irr_o
);
  logic valid_q, irr_q, lvl_q;
  msg_t msg_q;
  logic lvl_mode, mode_ok, accept, fire, eoi_hit;
  logic [DEST_W-1:0] dest_res;

  // only fixed and lowest-priority honour level trigger
  assign lvl_mode = cfg_i.level && (cfg_i.mode == DM_FIXED || cfg_i.mode == DM_LOWPRI);
  assign mode_ok  = !(cfg_i.mode == DM_RSV3 || cfg_i.mode == DM_RSV6);
  assign accept   = valid_q && ready_i;
  assign fire     = !valid_q && !cfg_i.mask && mode_ok &&
                    (lvl_mode ? (cond_i && !irr_q) : edge_i);
  assign eoi_hit  = eoi_valid_i && (eoi_vector_i == cfg_i.vec);
  assign dest_res = cfg_i.logical ? cfg_i.dest
                                  : {{(DEST_W-PHYS_W){1'b0}}, cfg_i.dest[PHYS_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      lvl_q   <= 1'b0;
      msg_q   <= '0;
    end else if (accept) begin
      valid_q <= 1'b0;
    end else if (fire) begin
      valid_q       <= 1'b1;
      lvl_q         <= lvl_mode;
      msg_q.vec     <= cfg_i.vec;
      msg_q.mode    <= cfg_i.mode;
      msg_q.logical <= cfg_i.logical;
      msg_q.dest    <= dest_res;
    end
  end

  // acceptance of a level message wins over a same-cycle EOI
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              irr_q <= 1'b0;
    else if (accept && lvl_q) irr_q <= 1'b1;
    else if (eoi_hit)         irr_q <= 1'b0;
  end

  assign valid_o = valid_q;
  assign msg_o   = msg_q;
  assign irr_o   = irr_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ready_i |=> valid_q && $stable(msg_q));
  p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && ready_i |=> !valid_q);
  p_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> !$past(cfg_i.mask));
  p_rsv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> !(msg_q.mode == DM_RSV3 || msg_q.mode == DM_RSV6));
  p_irr_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && ready_i && lvl_q |=> irr_q);
  p_irr_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) && $past(irr_q) |-> !lvl_q);
  p_phys_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !msg_q.logical |-> msg_q.dest[DEST_W-1:PHYS_W] == '0);
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_entry_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_lo_o,
  output logic [WORD_W-1:0] rdata_hi_o,
  input  logic              irq_pin_i,
  input  logic              eoi_valid_i,
  input  logic [VEC_W-1:0]  eoi_vector_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [VEC_W-1:0]  req_vector_o,
  output logic [2:0]        req_mode_o,
  output logic              req_logical_o,
  output logic [DEST_W-1:0] req_dest_o
);
  cfg_t cfg;
  msg_t msg;
  logic cond, edge_det, valid, irr;

  irq_entry_regs u_regs (
    .clk_i, .rst_ni, .wr_lo_i, .wr_hi_i, .wdata_i,
    .pending_i (valid),
    .irr_i     (irr),
    .cfg_o     (cfg),
    .rdata_lo_o, .rdata_hi_o
  );

  irq_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk_i, .rst_ni,
    .pin_i      (irq_pin_i),
    .polarity_i (cfg.polarity),
    .cond_o     (cond),
    .edge_o     (edge_det)
  );

  irq_entry_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .cfg_i        (cfg),
    .cond_i       (cond),
    .edge_i       (edge_det),
    .eoi_valid_i, .eoi_vector_i,
    .ready_i      (req_ready_i),
    .valid_o      (valid),
    .msg_o        (msg),
    .irr_o        (irr)
  );

  assign req_valid_o   = valid;
  assign req_vector_o  = msg.vec;
  assign req_mode_o    = msg.mode;
  assign req_logical_o = msg.logical;
  assign req_dest_o    = msg.dest;

  p_status_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> rdata_lo_o[12]);
endmodule

// File: tb/tb_irq_route_entry.sv
`timescale 1ns/1ps
module tb_irq_route_entry;
  logic clk = 0, rst_n = 0;
  logic wr_lo = 0, wr_hi = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata_lo, rdata_hi;
  logic pin = 0, eoi_v = 0, ready = 0;
  logic [7:0] eoi_vec = 0;
  logic req_valid, req_logical;
  logic [7:0] req_vec, req_dest;
  logic [2:0] req_mode;

  always #2.5 clk = ~clk;

  irq_route_entry dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata),
    .rdata_lo_o(rdata_lo), .rdata_hi_o(rdata_hi), .irq_pin_i(pin),
    .eoi_valid_i(eoi_v), .eoi_vector_i(eoi_vec), .req_valid_o(req_valid),
    .req_ready_i(ready), .req_vector_o(req_vec), .req_mode_o(req_mode),
    .req_logical_o(req_logical), .req_dest_o(req_dest)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int s1, s2, prev, m_vec, m_mode, m_dm, m_pol, m_trig, m_mask, m_dest;
  int m_valid, m_irr, m_lvl, l_vec, l_mode, l_dm, l_dest;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; prev = 0; m_vec = 0; m_mode = 0; m_dm = 0; m_pol = 0;
      m_trig = 0; m_mask = 1; m_dest = 0; m_valid = 0; m_irr = 0; m_lvl = 0;
      l_vec = 0; l_mode = 0; l_dm = 0; l_dest = 0;
    end else begin
      int cnd, edg, ok, lvl, acc, raise, n_irr;
      cnd   = s2 ^ m_pol;
      edg   = cnd && !prev;
      ok    = (m_mode != 3) && (m_mode != 6);
      lvl   = m_trig && (m_mode == 0 || m_mode == 1);
      acc   = m_valid && ready;
      raise = !m_valid && !m_mask && ok && (lvl ? (cnd && !m_irr) : edg);
      n_irr = m_irr;
      if (eoi_v && eoi_vec == m_vec) n_irr = 0;
      if (acc && m_lvl) n_irr = 1;
      m_irr = n_irr;
      if (acc) m_valid = 0;
      else if (raise) begin
        m_valid = 1; m_lvl = lvl; l_vec = m_vec; l_mode = m_mode; l_dm = m_dm;
        l_dest = m_dm ? m_dest : (m_dest % 16);
      end
      if (wr_lo) begin
        m_vec = wdata[7:0]; m_mode = wdata[10:8]; m_dm = wdata[11];
        m_pol = wdata[13]; m_trig = wdata[15]; m_mask = wdata[16];
      end
      if (wr_hi) m_dest = wdata[31:24];
      prev = cnd; s2 = s1; s1 = pin;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    logic [31:0] exp_lo;
    exp_lo = m_vec | (m_mode << 8) | (m_dm << 11) | (m_valid << 12) | (m_pol << 13)
           | (m_irr << 14) | (m_trig << 15) | (m_mask << 16);
    expect_eq("R4 model valid", {31'b0, req_valid}, m_valid);
    expect_eq("R2 model low word", rdata_lo, exp_lo);
    expect_eq("R2 model high word", rdata_hi, m_dest << 24);
    if (m_valid) begin
      expect_eq("R9 model vector", {24'b0, req_vec}, l_vec);
      expect_eq("R9 model mode", {29'b0, req_mode}, l_mode);
      expect_eq("R10 model logical", {31'b0, req_logical}, l_dm);
      expect_eq("R10 model dest", {24'b0, req_dest}, l_dest);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic write_lo(logic [31:0] d);
    @(negedge clk); wr_lo = 1; wdata = d;
    @(negedge clk); wr_lo = 0;
  endtask
  task automatic write_hi(logic [31:0] d);
    @(negedge clk); wr_hi = 1; wdata = d;
    @(negedge clk); wr_hi = 0;
  endtask
  task automatic accept_one();
    @(negedge clk); ready = 1;
    @(negedge clk); ready = 0;
  endtask
  task automatic send_eoi(logic [7:0] v);
    @(negedge clk); eoi_v = 1; eoi_vec = v;
    @(negedge clk); eoi_v = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1; failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1; step(1);
    // R1 reset state
    expect_eq("R1 low word", rdata_lo, 32'h0001_0000);
    expect_eq("R1 high word", rdata_hi, 32'h0);
    expect_eq("R1 valid", {31'b0, req_valid}, 0);

    // R2 field writes
    write_hi(32'hA512_3456);
    expect_eq("R2 high write", rdata_hi, 32'hA500_0000);
    write_lo(32'hFFFF_FFFF);
    expect_eq("R2 low write", rdata_lo, 32'h0001_AFFF);

    // R3 latency, R10 physical dest, R9 hold
    write_lo(32'h0000_0031);
    step(3);
    pin = 1;
    step(1); expect_eq("R3 edge1", {31'b0, req_valid}, 0);
    step(1); expect_eq("R3 edge2", {31'b0, req_valid}, 0);
    step(1); expect_eq("R3 edge3", {31'b0, req_valid}, 1);
    expect_eq("R4 status bit", {31'b0, rdata_lo[12]}, 1);
    expect_eq("R10 physical dest", {24'b0, req_dest}, 32'h05);
    step(4);
    expect_eq("R9 held valid", {31'b0, req_valid}, 1);
    expect_eq("R9 held vector", {24'b0, req_vec}, 32'h31);
    accept_one();
    expect_eq("R9 cleared", {31'b0, req_valid}, 0);
    expect_eq("R9 status cleared", {31'b0, rdata_lo[12]}, 0);
    pin = 0; step(3);

    // R4 masked edge dropped
    write_lo(32'h0001_0031);
    pin = 1; step(4);
    write_lo(32'h0000_0031); step(4);
    expect_eq("R4 masked edge dropped", {31'b0, req_valid}, 0);
    pin = 0; step(3);

    // R4 edge while pending dropped
    pin = 1; step(4);
    expect_eq("R4 raised", {31'b0, req_valid}, 1);
    pin = 0; step(3); pin = 1; step(4);
    accept_one(); step(4);
    expect_eq("R4 pending edge dropped", {31'b0, req_valid}, 0);
    pin = 0; step(3);

    // R5/R6 level lowest-priority logical
    write_lo(32'h0000_8942);
    pin = 1; step(4);
    expect_eq("R5 level raise", {31'b0, req_valid}, 1);
    expect_eq("R10 logical dest", {24'b0, req_dest}, 32'hA5);
    accept_one();
    expect_eq("R5 irr set", {31'b0, rdata_lo[14]}, 1);
    step(5);
    expect_eq("R5 blocked by irr", {31'b0, req_valid}, 0);
    send_eoi(8'h43); step(2);
    expect_eq("R6 mismatched eoi", {31'b0, rdata_lo[14]}, 1);
    expect_eq("R6 no request", {31'b0, req_valid}, 0);
    send_eoi(8'h42);
    expect_eq("R6 irr cleared", {31'b0, rdata_lo[14]}, 0);
    step(1);
    expect_eq("R6 re-request", {31'b0, req_valid}, 1);
    accept_one(); pin = 0; send_eoi(8'h42); step(4);
    expect_eq("R6 idle after release", {31'b0, req_valid}, 0);

    // R7 NMI with level trigger set
    write_lo(32'h0000_8400);
    pin = 1; step(4);
    expect_eq("R7 nmi raise", {31'b0, req_valid}, 1);
    expect_eq("R7 nmi mode", {29'b0, req_mode}, 3'b100);
    accept_one();
    expect_eq("R7 no irr", {31'b0, rdata_lo[14]}, 0);
    step(10);
    expect_eq("R7 single request", {31'b0, req_valid}, 0);
    pin = 0; step(3);

    // R8 reserved codes
    write_lo(32'h0000_0300); pin = 1; step(5);
    expect_eq("R8 code 011", {31'b0, req_valid}, 0);
    pin = 0; step(3);
    write_lo(32'h0000_0600); pin = 1; step(5);
    expect_eq("R8 code 110", {31'b0, req_valid}, 0);
    pin = 0; step(3);

    // R11 active-low polarity
    write_lo(32'h0001_0000); pin = 1; step(4);
    write_lo(32'h0001_2000); step(3);
    write_lo(32'h0000_2000); step(3);
    expect_eq("R11 high pin idle", {31'b0, req_valid}, 0);
    pin = 0; step(4);
    expect_eq("R11 falling edge raises", {31'b0, req_valid}, 1);
    accept_one(); step(2);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(7) == 0) pin = ~pin;
      ready = ($urandom_range(3) != 0);
      eoi_v = ($urandom_range(9) == 0);
      eoi_vec = ($urandom_range(1) == 0) ? rdata_lo[7:0] : 8'($urandom);
      wr_lo = ($urandom_range(60) == 0);
      wr_hi = ($urandom_range(80) == 0);
      wdata = $urandom;
      if (wr_lo) wdata[16] = ($urandom_range(4) == 0);
    end
    @(negedge clk); wr_lo = 0; wr_hi = 0; eoi_v = 0; ready = 0;
    step(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule